// File: doc/BRIEF.md
# Timed SPI Command Sequencer with Write Flush

This block is an SPI master for a peripheral that takes 16-bit command frames and now and then drops a write. Each request carries a frame word, a last-in-burst flag and a parity enable. The sequencer classifies the word by its two top bits and fixes up the parity/next bit. It rejects the reserved class. Each frame is shifted out MSB first in SPI mode 0. Chip-select is held low for a stretched minimum, and the lead, lag and inter-frame gaps are enforced. All of these are counted in system clock cycles, rounded up from nanosecond parameters.

When a write frame marked last-in-burst has been sent, the sequencer adds one harmless read frame before it accepts any further request. By default this is the identity read 0x2580. A dropped write is then carried through by the frame that follows it. The word captured from MISO is returned for every frame, and an appended frame is marked as auto-inserted.

Top module: `spi_cmd_seq`

## Requirements
- R1: A request whose bits 15:14 are 00 (register/state read) or 11 (flag read) is sent with all bits unchanged except bit 8, which is forced to 1.
- R2: A request whose bits 15:14 are 01 (write) is sent with all bits unchanged except bit 8. When req_par_en_i is 1, bit 8 is the XOR of the other 15 bits, so the frame has even parity. When req_par_en_i is 0, bit 8 is 0.
- R3: A request whose bits 15:14 are 10 is consumed without any frame. err_o is high for exactly one cycle, the cycle after acceptance.
- R4: Frames are shifted MSB first in SPI mode 0. SCLK idles low and gives exactly 16 rising edges per frame, and MOSI changes only while SCLK is low.
- R5: From chip-select falling to the first SCLK rise there are exactly ceil(LEAD_NS/CLK_PERIOD_NS) cycles (110 at defaults).
- R6: From the last SCLK fall to chip-select rising there are at least ceil(LAG_NS/CLK_PERIOD_NS) cycles (6 at defaults).
- R7: Chip-select stays low for at least ceil(CS_LOW_NS/CLK_PERIOD_NS) cycles. When the shift itself is shorter, it stays low for exactly that number (1101 at defaults).
- R8: Between two frames, chip-select stays high for at least ceil(CS_HIGH_NS/CLK_PERIOD_NS) cycles (20 at defaults).
- R9: After a write frame accepted with req_last_i=1, exactly one frame carrying FLUSH_WORD (0x2580) is sent next, ahead of any waiting request. No frame is added after a read, or after a write with req_last_i=0.
- R10: In the cycle chip-select rises, rsp_valid_o is high for one cycle. rsp_word_o then holds the 16 MISO bits sampled on the SCLK rising edges, first bit in bit 15. rsp_auto_o is 1 only for an appended frame.
- R11: While rst_ni is low, cs_no is 1, sclk_o is 0, and rsp_valid_o and err_o are 0. After reset, req_ready_o is 1.
- R12: req_ready_o is 0 while a frame is in progress and while an appended frame is still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken on this edge when valid |
| req_word_i | input | 16 | Frame word to send |
| req_last_i | input | 1 | Request ends a burst |
| req_par_en_i | input | 1 | Write parity enable |
| err_o | output | 1 | Reserved-class request rejected (pulse) |
| rsp_valid_o | output | 1 | Response word strobe |
| rsp_word_o | output | 16 | Word received on MISO |
| rsp_auto_o | output | 1 | Response belongs to an appended frame |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | Chip-select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The owed flush read and a fresh user request can both be due in the same idle cycle. The bench provokes this by raising the next request as soon as a last-in-burst write has been taken, so the request waits through the whole write frame. The outcome is judged from the order of frames captured on MOSI, which must show the flush word, marked auto-inserted, before the waiting request. A reserved request that arrives while the engine is idle is also checked: err_o must pulse and no chip-select activity may follow.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    OP_RD_REG = 2'b00,
    OP_WRITE  = 2'b01,
    OP_RSVD   = 2'b10,
    OP_RD_FLG = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HI,
    ST_LO,
    ST_LAG,
    ST_GAP
  } eng_st_e;

  // ns to clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/spi_frame_fmt.sv
module spi_frame_fmt
  import spi_seq_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int PN_BIT  = 8
) (
  input  logic [FRAME_W-1:0] word_i,
  input  logic               par_en_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               is_wr_o,
  output logic               is_rsvd_o
);

  op_e                op;
  logic [FRAME_W-1:0] rest;
  logic               par;

  assign op        = op_e'(word_i[FRAME_W-1 -: 2]);
  assign is_wr_o   = (op == OP_WRITE);
  assign is_rsvd_o = (op == OP_RSVD);

  always_comb begin
    rest         = word_i;
    rest[PN_BIT] = 1'b0;
    par          = ^rest;
    word_o       = word_i;
    word_o[PN_BIT] = is_wr_o ? (par_en_i & par) : 1'b1;
  end

endmodule

// File: rtl/spi_frame_eng.sv
module spi_frame_eng
  import spi_seq_pkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter int LEAD_CYC  = 110,
  parameter int HALF_CYC  = 10,
  parameter int LAG_CYC   = 6,
  parameter int CSLOW_CYC = 1101,
  parameter int GAP_CYC   = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               auto_i,
  output logic               idle_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               rsp_valid_o,
  output logic [FRAME_W-1:0] rsp_word_o,
  output logic               rsp_auto_o
);

  localparam int SPAN  = CSLOW_CYC + LEAD_CYC + 2 * HALF_CYC * FRAME_W + LAG_CYC + GAP_CYC + 2;
  localparam int CNT_W = $clog2(SPAN) + 1;
  localparam int BIT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEAD_M1  = CNT_W'(LEAD_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_M1  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] LAG_M1   = CNT_W'(LAG_CYC - 1);
  localparam logic [CNT_W-1:0] CSLOW_M1 = CNT_W'(CSLOW_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_M1   = CNT_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  eng_st_e            st;
  logic [CNT_W-1:0]   ph;
  logic [CNT_W-1:0]   low_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] tx_sh;
  logic [FRAME_W-1:0] rx_sh;
  logic               tag;

  assign idle_o = (st == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      ph          <= '0;
      low_cnt     <= '0;
      bit_cnt     <= '0;
      tx_sh       <= '0;
      rx_sh       <= '0;
      tag         <= 1'b0;
      sclk_o      <= 1'b0;
      cs_no       <= 1'b1;
      mosi_o      <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_word_o  <= '0;
      rsp_auto_o  <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (!cs_no) low_cnt <= low_cnt + 1'b1;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            tx_sh   <= word_i;
            tag     <= auto_i;
            cs_no   <= 1'b0;
            mosi_o  <= word_i[FRAME_W-1];
            ph      <= '0;
            low_cnt <= '0;
            bit_cnt <= '0;
            st      <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          ph <= ph + 1'b1;
          if (ph == LEAD_M1) begin
            sclk_o <= 1'b1;
            rx_sh  <= {rx_sh[FRAME_W-2:0], miso_i};
            ph     <= '0;
            st     <= ST_HI;
          end
        end
        ST_HI: begin
          ph <= ph + 1'b1;
          if (ph == HALF_M1) begin
            sclk_o  <= 1'b0;
            ph      <= '0;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              st <= ST_LAG;
            end else begin
              tx_sh  <= {tx_sh[FRAME_W-2:0], 1'b0};
              mosi_o <= tx_sh[FRAME_W-2];
              st     <= ST_LO;
            end
          end
        end
        ST_LO: begin
          ph <= ph + 1'b1;
          if (ph == HALF_M1) begin
            sclk_o <= 1'b1;
            rx_sh  <= {rx_sh[FRAME_W-2:0], miso_i};
            ph     <= '0;
            st     <= ST_HI;
          end
        end
        ST_LAG: begin
          ph <= ph + 1'b1;
          // release only once both lag and stretched low time are met
          if (ph >= LAG_M1 && low_cnt >= CSLOW_M1) begin
            cs_no       <= 1'b1;
            rsp_valid_o <= 1'b1;
            rsp_word_o  <= rx_sh;
            rsp_auto_o  <= tag;
            ph          <= '0;
            st          <= ST_GAP;
          end
        end
        ST_GAP: begin
          ph <= ph + 1'b1;
          if (ph >= GAP_M1) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int                 CLK_PERIOD_NS = 5,
  parameter int                 FRAME_W       = 16,
  parameter int                 PN_BIT        = 8,
  parameter int                 LEAD_NS       = 550,
  parameter int                 LAG_NS        = 30,
  parameter int                 CS_LOW_NS     = 5505,
  parameter int                 CS_HIGH_NS    = 100,
  parameter int                 SCLK_HALF_NS  = 50,
  parameter logic [FRAME_W-1:0] FLUSH_WORD    = 16'h2580
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [FRAME_W-1:0] req_word_i,
  input  logic               req_last_i,
  input  logic               req_par_en_i,
  output logic               err_o,
  output logic               rsp_valid_o,
  output logic [FRAME_W-1:0] rsp_word_o,
  output logic               rsp_auto_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i
);

  localparam int LEAD_CYC  = ns2cyc(LEAD_NS, CLK_PERIOD_NS);
  localparam int LAG_CYC   = ns2cyc(LAG_NS, CLK_PERIOD_NS);
  localparam int CSLOW_CYC = ns2cyc(CS_LOW_NS, CLK_PERIOD_NS);
  localparam int GAP_CYC   = ns2cyc(CS_HIGH_NS, CLK_PERIOD_NS);
  localparam int HALF_CYC  = ns2cyc(SCLK_HALF_NS, CLK_PERIOD_NS);

  logic [FRAME_W-1:0] fmt_word;
  logic               fmt_wr;
  logic               fmt_rsvd;
  logic               eng_idle;
  logic               flush_pend;
  logic               acc;
  logic               start;
  logic [FRAME_W-1:0] start_word;

  spi_frame_fmt #(
    .FRAME_W (FRAME_W),
    .PN_BIT  (PN_BIT)
  ) i_fmt (
    .word_i    (req_word_i),
    .par_en_i  (req_par_en_i),
    .word_o    (fmt_word),
    .is_wr_o   (fmt_wr),
    .is_rsvd_o (fmt_rsvd)
  );

  assign req_ready_o = eng_idle & ~flush_pend;
  assign acc         = req_valid_i & req_ready_o;
  // an owed flush wins over any waiting request
  assign start       = eng_idle & (flush_pend | (req_valid_i & ~fmt_rsvd));
  assign start_word  = flush_pend ? FLUSH_WORD : fmt_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_pend <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      err_o <= acc & fmt_rsvd;
      if (eng_idle && flush_pend) flush_pend <= 1'b0;
      else if (acc && fmt_wr && req_last_i) flush_pend <= 1'b1;
    end
  end

  spi_frame_eng #(
    .FRAME_W   (FRAME_W),
    .LEAD_CYC  (LEAD_CYC),
    .HALF_CYC  (HALF_CYC),
    .LAG_CYC   (LAG_CYC),
    .CSLOW_CYC (CSLOW_CYC),
    .GAP_CYC   (GAP_CYC)
  ) i_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .word_i      (start_word),
    .auto_i      (flush_pend),
    .idle_o      (eng_idle),
    .sclk_o      (sclk_o),
    .cs_no       (cs_no),
    .mosi_o      (mosi_o),
    .miso_i      (miso_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_word_o  (rsp_word_o),
    .rsp_auto_o  (rsp_auto_o)
  );

endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk
  import spi_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int CS_LOW_NS     = 5505,
  parameter int CS_HIGH_NS    = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o,
  input logic rsp_valid_o,
  input logic rsp_auto_o,
  input logic req_ready_o,
  input logic err_o
);

  localparam int CSLOW_CYC = ns2cyc(CS_LOW_NS, CLK_PERIOD_NS);
  localparam int GAP_CYC   = ns2cyc(CS_HIGH_NS, CLK_PERIOD_NS);

  int low_c;
  int hi_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_c <= 0;
      hi_c  <= GAP_CYC;
    end else begin
      low_c <= cs_no ? 0 : low_c + 1;
      if (!cs_no) hi_c <= 0;
      else if (hi_c < GAP_CYC) hi_c <= hi_c + 1;
    end
  end

  a_r4_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  a_r4_mosi_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  a_r10_rsp_at_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $rose(cs_no));

  a_r10_cs_rise_has_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> rsp_valid_o);

  a_r10_auto_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_auto_o && !$past(rsp_auto_o) |-> rsp_valid_o);

  a_r3_err_no_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cs_no);

  a_r12_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_no);

  a_r7_cs_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (low_c >= CSLOW_CYC));

  a_r8_cs_high_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_c >= GAP_CYC));

endmodule

bind spi_cmd_seq spi_cmd_seq_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .CS_LOW_NS     (CS_LOW_NS),
  .CS_HIGH_NS    (CS_HIGH_NS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_no       (cs_no),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_auto_o  (rsp_auto_o),
  .req_ready_o (req_ready_o),
  .err_o       (err_o)
);

// File: tb/test_spi_cmd_seq.sv
`timescale 1ns/1ps
module test_spi_cmd_seq;

  localparam int LEAD_C  = 110;
  localparam int LAG_C   = 6;
  localparam int CSLOW_C = 1101;
  localparam int GAP_C   = 20;
  localparam logic [15:0] FLUSH = 16'h2580;

  typedef struct packed {
    logic [15:0] w;
    logic        last;
    logic        par;
    logic [15:0] exp;
    logic        rsvd;
    logic        flush;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h2000, 1'b1, 1'b0, 16'h2100, 1'b0, 1'b0},  // R1 00 class, bit8 forced
    '{16'h0000, 1'b0, 1'b0, 16'h0100, 1'b0, 1'b0},  // R1
    '{16'hC0A5, 1'b1, 1'b1, 16'hC1A5, 1'b0, 1'b0},  // R1 11 class
    '{16'h60C0, 1'b0, 1'b0, 16'h60C0, 1'b0, 1'b0},  // R2 write mid burst
    '{16'h67C0, 1'b1, 1'b0, 16'h66C0, 1'b0, 1'b1},  // R2 bit8 cleared, R9 flush
    '{16'h7FFF, 1'b1, 1'b1, 16'h7EFF, 1'b0, 1'b1},  // R2 parity 0
    '{16'h4003, 1'b0, 1'b1, 16'h4103, 1'b0, 1'b0},  // R2 parity 1
    '{16'h8123, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0},  // R3 reserved
    '{16'h5F00, 1'b1, 1'b0, 16'h5E00, 1'b0, 1'b1}   // R9
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [15:0] req_word_i = '0;
  logic        req_last_i = 1'b0;
  logic        req_par_en_i = 1'b0;
  logic        err_o;
  logic        rsp_valid_o;
  logic [15:0] rsp_word_o;
  logic        rsp_auto_o;
  logic        sclk_o;
  logic        cs_no;
  logic        mosi_o;
  logic        miso_i = 1'b0;

  always #2.5 clk_i = ~clk_i;

  spi_cmd_seq i_spi_cmd_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_word_i, .req_last_i,
    .req_par_en_i, .err_o, .rsp_valid_o, .rsp_word_o, .rsp_auto_o,
    .sclk_o, .cs_no, .mosi_o, .miso_i
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected frame list
  logic [15:0] exp_w [32];
  logic        exp_a [32];
  int          n_exp = 0;

  // slave model and monitor
  int          fidx = 0;
  int          n_rsp = 0;
  logic        p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;
  logic [15:0] s_tx, cap;
  int          nrise, lowc, leadc, lagc, hic;
  bit          mosi_bad;

  function automatic logic [15:0] pat(input int i);
    return 16'hC3A0 ^ 16'(i * 16'h0111);
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rsp_valid_o) n_rsp++;
      if (p_cs && !cs_no) begin
        if (fidx > 0) chk(hic >= GAP_C, "R8 cs high gap", hic, GAP_C);
        s_tx = pat(fidx); miso_i <= s_tx[15];
        nrise = 0; lowc = 0; leadc = 0; lagc = 0; cap = '0; mosi_bad = 1'b0;
      end
      if (cs_no) hic++;
      else begin
        hic = 0;
        lowc++;
        if (!sclk_o && nrise == 0) leadc++;
        if (!sclk_o && nrise == 16) lagc++;
        if (sclk_o && p_sclk && mosi_o != p_mosi) mosi_bad = 1'b1;
        if (sclk_o && !p_sclk) begin cap = {cap[14:0], mosi_o}; nrise++; end
        if (!sclk_o && p_sclk) begin s_tx = {s_tx[14:0], 1'b0}; miso_i <= s_tx[15]; end
      end
      if (!p_cs && cs_no) begin
        chk(fidx < n_exp, "R9 no extra frame", fidx, n_exp);
        chk(cap == exp_w[fidx], "R1/R2/R9 mosi word", cap, exp_w[fidx]);
        chk(nrise == 16 && !mosi_bad, "R4 16 edges, mosi steady", nrise, 16);
        chk(leadc == LEAD_C, "R5 lead", leadc, LEAD_C);
        chk(lagc >= LAG_C, "R6 lag", lagc, LAG_C);
        chk(lowc == CSLOW_C, "R7 cs low", lowc, CSLOW_C);
        chk(rsp_valid_o, "R10 rsp valid", rsp_valid_o, 1);
        chk(rsp_word_o == pat(fidx), "R10 rsp word", rsp_word_o, pat(fidx));
        chk(rsp_auto_o == exp_a[fidx], "R10 auto tag", rsp_auto_o, exp_a[fidx]);
        fidx++;
      end
      p_cs = cs_no; p_sclk = sclk_o; p_mosi = mosi_o;
    end else begin
      p_cs = 1'b1; p_sclk = 1'b0; hic = GAP_C;
    end
  end

  task automatic send(input vec_t v);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_word_i = v.w; req_last_i = v.last; req_par_en_i = v.par;
    while (!req_ready_o) @(negedge clk_i);
    if (!v.rsvd) begin exp_w[n_exp] = v.exp; exp_a[n_exp] = 1'b0; n_exp++; end
    if (v.flush) begin exp_w[n_exp] = FLUSH; exp_a[n_exp] = 1'b1; n_exp++; end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(err_o == v.rsvd, "R3 err pulse", err_o, v.rsvd);
    if (v.rsvd) begin
      @(negedge clk_i);
      chk(!err_o && cs_no, "R3 single pulse, no frame", {err_o, cs_no}, 2'b01);
    end else begin
      chk(!req_ready_o, "R12 ready low in frame", req_ready_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", fidx, n_exp);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    chk(cs_no && !sclk_o && !rsp_valid_o && !err_o, "R11 reset outputs",
        {cs_no, sclk_o, rsp_valid_o, err_o}, 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o, "R11 ready after reset", req_ready_o, 1);
    for (int i = 0; i < NV; i++) send(VECS[i]);
    for (int t = 0; t < 20000 && fidx < n_exp; t++) @(negedge clk_i);
    repeat (3000) @(negedge clk_i);
    chk(fidx == n_exp, "R9 frame count", fidx, n_exp);
    chk(n_rsp == n_exp, "R10 one strobe per frame", n_rsp, n_exp);
    chk(cs_no && req_ready_o, "R12 idle ready at end", {cs_no, req_ready_o}, 2'b11);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule